// File: doc/BRIEF.md
# Dual-Channel Bidirectional Latched Transceiver

This block links an A side to a B side through two independent 8-bit channels. Each channel has two storage paths, one for A-to-B traffic and one for B-to-A traffic. Every path has three active-low controls: a path select, a latch gate and a drive enable. Together they decide two things: whether the path's latch follows its input or keeps its contents, and whether the far side is driven or released.

The sides are modelled as separate data-in, data-out and per-bit drive-enable vectors. An enclosing level can fold these onto shared bidirectional pins. Storage is level-sensitive. A path is transparent only while both its select and its gate are low. It keeps the last value it saw when either one rises. The far side is driven only while both the select and the drive enable are low. The two channels do not interact, and neither do the two directions within a channel.

Top module: `dual_latch_xcvr`

## Requirements
- R1: With a path's select, gate and drive enable all low, the far side's data output equals the current near-side input, and it follows every change of that input.
- R2: When a path's gate rises while its select is low, the path keeps the near-side value present before the rise. Later changes of the near-side input do not reach the far side while the gate stays high.
- R3: While a path's select is high, its latch keeps its contents whatever the gate does, and the far-side drive enable is all zeros.
- R4: While a path's drive enable is high, the far-side drive enable is all zeros. The latch still loads while select and gate are low, and the loaded value appears once the drive enable is lowered.
- R5: With select low, gate high and drive enable low, the far side drives the stored value, not the current near-side input.
- R6: A channel's far-side drive-enable slice is all ones (8'hFF) while that path drives and all zeros (8'h00) otherwise.
- R7: The B-to-A path obeys R1 to R6 with B as input and A as output, using its own three controls.
- R8: Channel 0 occupies bits 7:0 and channel 1 occupies bits 15:8 of every data and enable vector. A control or data change on one path leaves the outputs of the other three paths unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ab_sel_n | input | 2 | A-to-B path select per channel, active low |
| ab_gate_n | input | 2 | A-to-B latch gate per channel, active low (transparent) |
| ab_drv_n | input | 2 | A-to-B drive enable per channel, active low |
| ba_sel_n | input | 2 | B-to-A path select per channel, active low |
| ba_gate_n | input | 2 | B-to-A latch gate per channel, active low (transparent) |
| ba_drv_n | input | 2 | B-to-A drive enable per channel, active low |
| a_in | input | 16 | A side data seen by the A-to-B latches |
| a_out | output | 16 | B-to-A latch contents presented to the A side |
| a_oe | output | 16 | Per-bit drive enable for the A side |
| b_in | input | 16 | B side data seen by the B-to-A latches |
| b_out | output | 16 | A-to-B latch contents presented to the B side |
| b_oe | output | 16 | Per-bit drive enable for the B side |

## Verification
The hardest condition to reach from the ports is a latch that loaded new data while its output was released. Nothing shows that load until the drive enable returns. A second hard condition is a latch that ignored data because its select was high, even though its gate was low. The stimulus reaches the first by lowering the gate with the drive enable high, changing the input, and only then re-enabling the drive. It reaches the second by presenting fresh data with select high and gate low, then re-selecting with the gate closed so that the old value must reappear. Every step also predicts all four paths, so a leak between channels or directions shows up at once.

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr #(
  parameter int CHANNELS = 2,
  parameter int WIDTH    = 8,
  localparam int BUS     = CHANNELS * WIDTH
) (
  input  logic [CHANNELS-1:0] ab_sel_n,
  input  logic [CHANNELS-1:0] ab_gate_n,
  input  logic [CHANNELS-1:0] ab_drv_n,
  input  logic [CHANNELS-1:0] ba_sel_n,
  input  logic [CHANNELS-1:0] ba_gate_n,
  input  logic [CHANNELS-1:0] ba_drv_n,
  input  logic [BUS-1:0]      a_in,
  output logic [BUS-1:0]      a_out,
  output logic [BUS-1:0]      a_oe,
  input  logic [BUS-1:0]      b_in,
  output logic [BUS-1:0]      b_out,
  output logic [BUS-1:0]      b_oe
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [WIDTH-1:0] ab_q;
    logic [WIDTH-1:0] ba_q;
    wire ab_open  = ~(ab_sel_n[c] | ab_gate_n[c]);
    wire ba_open  = ~(ba_sel_n[c] | ba_gate_n[c]);
    wire ab_drive = ~(ab_sel_n[c] | ab_drv_n[c]);
    wire ba_drive = ~(ba_sel_n[c] | ba_drv_n[c]);

    always_latch
      if (ab_open) ab_q = a_in[c*WIDTH +: WIDTH];

    always_latch
      if (ba_open) ba_q = b_in[c*WIDTH +: WIDTH];

    assign b_out[c*WIDTH +: WIDTH] = ab_q;
    assign a_out[c*WIDTH +: WIDTH] = ba_q;
    assign b_oe[c*WIDTH +: WIDTH]  = {WIDTH{ab_drive}};
    assign a_oe[c*WIDTH +: WIDTH]  = {WIDTH{ba_drive}};
  end

endmodule

module dual_latch_xcvr_chk #(
  parameter int CHANNELS = 2,
  parameter int WIDTH    = 8,
  localparam int BUS     = CHANNELS * WIDTH
) (
  input logic [CHANNELS-1:0] ab_sel_n,
  input logic [CHANNELS-1:0] ab_gate_n,
  input logic [CHANNELS-1:0] ab_drv_n,
  input logic [CHANNELS-1:0] ba_sel_n,
  input logic [CHANNELS-1:0] ba_gate_n,
  input logic [CHANNELS-1:0] ba_drv_n,
  input logic [BUS-1:0]      a_in,
  input logic [BUS-1:0]      a_out,
  input logic [BUS-1:0]      a_oe,
  input logic [BUS-1:0]      b_in,
  input logic [BUS-1:0]      b_out,
  input logic [BUS-1:0]      b_oe
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
    always_comb begin
      if (!ab_sel_n[c] && !ab_gate_n[c])
        assert_ab_follow_R1: assert (b_out[c*WIDTH +: WIDTH] == a_in[c*WIDTH +: WIDTH]);
      if (!ba_sel_n[c] && !ba_gate_n[c])
        assert_ba_follow_R7: assert (a_out[c*WIDTH +: WIDTH] == b_in[c*WIDTH +: WIDTH]);
      if (ab_sel_n[c])
        assert_ab_sel_off_R3: assert (b_oe[c*WIDTH +: WIDTH] == '0);
      if (ba_drv_n[c])
        assert_ba_drv_off_R4: assert (a_oe[c*WIDTH +: WIDTH] == '0);
      assert_ab_oe_whole_R6: assert (b_oe[c*WIDTH +: WIDTH] == '0 || b_oe[c*WIDTH +: WIDTH] == '1);
    end
  end

endmodule

bind dual_latch_xcvr dual_latch_xcvr_chk #(.CHANNELS(CHANNELS), .WIDTH(WIDTH)) u_chk (
  .ab_sel_n(ab_sel_n), .ab_gate_n(ab_gate_n), .ab_drv_n(ab_drv_n),
  .ba_sel_n(ba_sel_n), .ba_gate_n(ba_gate_n), .ba_drv_n(ba_drv_n),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/sim_dual_latch_xcvr.sv
module sim_dual_latch_xcvr;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  ab_sel_n = '1, ab_gate_n = '1, ab_drv_n = '1;
  logic [1:0]  ba_sel_n = '1, ba_gate_n = '1, ba_drv_n = '1;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, a_oe, b_out, b_oe;

  dual_latch_xcvr u0 (.*);

  int total = 0;
  int bad = 0;

  typedef struct { int ch; bit dir; logic [7:0] eoe; logic [7:0] edat; } item_t;
  item_t  q[$];
  string  tq[$];
  logic [7:0] ref_q [2][2];
  bit     ref_set [2][2];

  function automatic void predict(int ch, bit dir, string tag);
    item_t it;
    logic ce, le, oe;
    logic [7:0] din;
    ce  = dir ? ba_sel_n[ch]  : ab_sel_n[ch];
    le  = dir ? ba_gate_n[ch] : ab_gate_n[ch];
    oe  = dir ? ba_drv_n[ch]  : ab_drv_n[ch];
    din = dir ? b_in[ch*8 +: 8] : a_in[ch*8 +: 8];
    if (!ce && !le) begin ref_q[ch][dir] = din; ref_set[ch][dir] = 1'b1; end
    it.ch = ch; it.dir = dir;
    it.eoe  = (!ce && !oe) ? 8'hFF : 8'h00;
    it.edat = ref_q[ch][dir];
    q.push_back(it);
    tq.push_back(tag);
  endfunction

  task automatic step(input int ch, input bit dir, input logic ce, input logic le,
                      input logic oe, input logic [7:0] d, input string tag);
    @(posedge clk);
    if (dir) begin
      ba_sel_n[ch] = ce; ba_gate_n[ch] = le; ba_drv_n[ch] = oe; b_in[ch*8 +: 8] = d;
    end else begin
      ab_sel_n[ch] = ce; ab_gate_n[ch] = le; ab_drv_n[ch] = oe; a_in[ch*8 +: 8] = d;
    end
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 2; r++)
        predict(c, r[0], (c == ch && r[0] == dir) ? tag : "R8");
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      string tg;
      logic [7:0] got_oe, got_d;
      it = q.pop_front();
      tg = tq.pop_front();
      got_oe = it.dir ? a_oe[it.ch*8 +: 8]  : b_oe[it.ch*8 +: 8];
      got_d  = it.dir ? a_out[it.ch*8 +: 8] : b_out[it.ch*8 +: 8];
      total++;
      if (got_oe !== it.eoe || (it.eoe != 8'h00 && got_d !== it.edat)) begin
        bad++;
        $display("FAIL %s ch%0d dir%0d: oe=%h data=%h expected oe=%h data=%h",
                 tg, it.ch, it.dir, got_oe, got_d, it.eoe, it.edat);
      end
    end
  end

  task automatic path_seq(input int ch, input bit dir, input logic [7:0] s);
    string r1, r2, r3, r4, r5, r6;
    r1 = dir ? "R7" : "R1"; r2 = dir ? "R7" : "R2"; r3 = dir ? "R7" : "R3";
    r4 = dir ? "R7" : "R4"; r5 = dir ? "R7" : "R5"; r6 = dir ? "R7" : "R6";
    step(ch, dir, 0, 0, 0, s ^ 8'h5A, r1);
    step(ch, dir, 0, 0, 0, s ^ 8'hC3, r1);
    step(ch, dir, 0, 1, 0, s ^ 8'hC3, r2);
    step(ch, dir, 0, 1, 0, s ^ 8'h0F, r2);
    step(ch, dir, 0, 1, 0, s ^ 8'hF0, r5);
    step(ch, dir, 0, 1, 1, s ^ 8'hF0, r4);
    step(ch, dir, 0, 0, 1, s ^ 8'h99, r4);
    step(ch, dir, 0, 1, 1, s ^ 8'h99, r4);
    step(ch, dir, 0, 1, 0, s ^ 8'h66, r4);
    step(ch, dir, 1, 0, 0, s ^ 8'hA5, r3);
    step(ch, dir, 1, 1, 0, s ^ 8'h3C, r3);
    step(ch, dir, 0, 1, 0, s ^ 8'h3C, r3);
    step(ch, dir, 1, 1, 1, s ^ 8'h3C, r6);
  endtask

  bit done = 0;

  initial begin
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 2; r++) begin
        ref_q[c][r] = '0;
        ref_set[c][r] = 1'b0;
      end
    repeat (2) @(posedge clk);
    // initial state: everything released (R6)
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 2; r++) predict(c, r[0], "R6");
    // prime all latches with a transparent phase while outputs stay off
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 2; r++) begin
        step(c, r[0], 0, 0, 1, 8'h00, "R4");
        step(c, r[0], 1, 1, 1, 8'h00, "R3");
      end
    // park three paths driving stored data so R8 isolation is visible
    step(0, 1'b1, 0, 0, 0, 8'h11, "R7");
    step(0, 1'b1, 0, 1, 0, 8'h11, "R5");
    step(1, 1'b0, 0, 0, 0, 8'h22, "R1");
    step(1, 1'b0, 0, 1, 0, 8'h22, "R5");
    step(1, 1'b1, 0, 0, 0, 8'h33, "R7");
    step(1, 1'b1, 0, 1, 0, 8'h33, "R5");
    path_seq(0, 1'b0, 8'h00);
    path_seq(0, 1'b1, 8'h81);
    path_seq(1, 1'b0, 8'h42);
    path_seq(1, 1'b1, 8'h24);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule